// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers interrupt request lines from several devices and presents them to a processor on one request output. Each request line is watched for rising edges. An edge is held as a pending bit until that source is served, so a request lasting a single cycle is not lost. A per-source enable input decides which pending bits may raise the processor request. When several enabled sources are pending at once, the source with the lowest line number wins.

The processor answers with two active-low acknowledge pulses:

- **First pulse:** the controller records the winning source and withdraws its request.
- **Second pulse:** the controller drives a vector onto an 8-bit data bus, with a bus-enable. The vector is a programmable base plus the winner's index.

When the second pulse ends, the served source's pending bit is cleared. If other enabled requests remain, the request output rises again. While a handshake is in progress, a one-hot in-service output shows which source is being served. All inputs are treated as synchronous to the block clock.

Top module: `vic_top`

## Requirements
- R1: After reset, cpu_int, bus_oe, bus_data and in_service are all zero.
- R2: cpu_int goes high two clock edges after a rising edge on an enabled request line. A pending bit whose enable is low keeps cpu_int low but stays latched, and it raises cpu_int once its enable is set.
- R3: A request high for only one cycle is latched. A request held high counts as one event, so it raises cpu_int only once.
- R4: When inta_n is low while cpu_int is high, cpu_int is low from the next cycle. The bus is not driven during this first low phase.
- R5: During the second inta_n low phase, bus_data equals (vec_base + winner index) modulo 256.
- R6: Among enabled pending lines, the lowest index wins. Bit 0 of irq_req is index 0.
- R7: The winner is fixed at the first inta_n low. A request that arrives between the pulses does not change the delivered vector.
- R8: The served source's pending bit is cleared on the first clock edge that sees inta_n high after the second low phase. cpu_int is high again one clock edge later if other enabled pending bits remain.
- R9: in_service is the one-hot of the winner from the first acknowledge low phase until the second phase ends, and zero at all other times.
- R10: bus_oe is high only during the second inta_n low phase. bus_data is zero whenever bus_oe is low.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Device request lines, edge-sensitive |
| irq_en | input | NSRC | Per-source enable for raising cpu_int |
| vec_base | input | VW | Base added to the winner index to form the vector |
| inta_n | input | 1 | Active-low acknowledge from the processor |
| cpu_int | output | 1 | Interrupt request to the processor |
| bus_oe | output | 1 | Data bus drive enable |
| bus_data | output | VW | Vector value, valid while bus_oe is high |
| in_service | output | NSRC | One-hot source currently being acknowledged |

## Verification
The bench raises a higher-priority request between the two acknowledge pulses. A design that picks its winner late would deliver the wrong vector there. It holds a request line high across a full service, which catches level-sensitive capture that would re-interrupt forever. It also pulses lines for one cycle, which catches designs that drop short events. Masked sources are left pending and enabled later, and a base near 255 checks that the vector wraps. Checks on cpu_int and bus_oe during the first pulse catch a bus driven too early or a request that stays up through the acknowledge.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ACK1,
    ST_GAP,
    ST_ACK2
  } ack_st_t;

  // vector arithmetic kept here so the bench can restate it independently
  function automatic logic [31:0] vec_sum(input logic [31:0] base, input logic [31:0] idx);
    return base + idx;
  endfunction

endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);

  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] rise;

  assign rise = req & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= req;
      pend  <= (pend & ~clr) | rise;
    end
  end

  // R3: every detected edge is latched
  a_r3_rise_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend & $past(rise)) == $past(rise)));

  // R8: a cleared source drops unless a fresh edge arrived
  a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~rise)) |=> ((pend & $past(clr & ~rise)) == '0));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req,
  output logic            any,
  output logic [IW-1:0]   idx
);

  function automatic logic [IW-1:0] lowest_set(input logic [NSRC-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign any = |req;
  assign idx = lowest_set(req);

  // R6: no lower-indexed request may be pending below the chosen one
  always_comb begin
    if (any) begin
      a_r6_lowest_wins: assert ((req & ((NSRC'(1) << idx) - NSRC'(1))) == '0);
    end
  end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import vic_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int VW   = 8,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inta_n,
  input  logic            any,
  input  logic [IW-1:0]   pick_idx,
  input  logic [VW-1:0]   base,
  output logic            cpu_int,
  output logic            bus_oe,
  output logic [VW-1:0]   bus_data,
  output logic [NSRC-1:0] in_service,
  output logic [NSRC-1:0] clr
);

  ack_st_t       st;
  logic [IW-1:0] win;
  logic          busy;
  logic          served;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      win <= '0;
    end else begin
      case (st)
        ST_IDLE: if (any) st <= ST_REQ;
        ST_REQ: begin
          if (!any) st <= ST_IDLE;
          else if (!inta_n) begin
            st  <= ST_ACK1;
            win <= pick_idx;
          end
        end
        ST_ACK1: if (inta_n) st <= ST_GAP;
        ST_GAP:  if (!inta_n) st <= ST_ACK2;
        ST_ACK2: if (inta_n) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st == ST_ACK1) || (st == ST_GAP) || (st == ST_ACK2);
  assign served     = (st == ST_ACK2) && inta_n;
  assign cpu_int    = (st == ST_REQ);
  assign bus_oe     = (st == ST_ACK2);
  assign bus_data   = bus_oe ? VW'(vec_sum(32'(base), 32'(win))) : '0;
  assign in_service = busy ? (NSRC'(1) << win) : '0;
  assign clr        = served ? (NSRC'(1) << win) : '0;

  // R4: acknowledge withdraws the request
  a_r4_int_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_int && !inta_n) |=> !cpu_int);

  // R10: drive stops once the second pulse ends
  a_r10_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && inta_n) |=> !bus_oe);

  // R9: one source at most in service
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_service));

  // R7: winner does not move during a handshake
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((|in_service) && $past(|in_service)) |-> $stable(in_service));

  // R5: driven vector always belongs to a source in service
  a_r5_oe_owner: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (|in_service));

endmodule

// File: rtl/vic_top.sv
module vic_top #(
  parameter int NSRC = 8,
  parameter int VW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic [VW-1:0]   vec_base,
  input  logic            inta_n,
  output logic            cpu_int,
  output logic            bus_oe,
  output logic [VW-1:0]   bus_data,
  output logic [NSRC-1:0] in_service
);

  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] live;
  logic [NSRC-1:0] clr;
  logic            any;
  logic [IW-1:0]   pick_idx;

  assign live = pend & irq_en;

  irq_capture #(.NSRC(NSRC)) u_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (irq_req),
    .clr  (clr),
    .pend (pend)
  );

  irq_prio_pick #(.NSRC(NSRC)) u_pick (
    .req(live),
    .any(any),
    .idx(pick_idx)
  );

  irq_ack_fsm #(.NSRC(NSRC), .VW(VW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .inta_n    (inta_n),
    .any       (any),
    .pick_idx  (pick_idx),
    .base      (vec_base),
    .cpu_int   (cpu_int),
    .bus_oe    (bus_oe),
    .bus_data  (bus_data),
    .in_service(in_service),
    .clr       (clr)
  );

  // R2: request output only with an enabled pending source
  a_r2_int_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> (|live));

endmodule

// File: tb/sim_vic_top.sv
module sim_vic_top;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic [N-1:0] irq_en = '0;
  logic [7:0]   vec_base = '0;
  logic         inta_n = 1'b1;
  logic         cpu_int;
  logic         bus_oe;
  logic [7:0]   bus_data;
  logic [N-1:0] in_service;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic done = 1'b0;
  logic [N-1:0] model = '0;

  always #5 clk = ~clk;

  vic_top #(.NSRC(N), .VW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .vec_base(vec_base), .inta_n(inta_n), .cpu_int(cpu_int),
    .bus_oe(bus_oe), .bus_data(bus_data), .in_service(in_service)
  );

  // {req, en, base}
  localparam logic [23:0] VEC [9] = '{
    {8'h05, 8'hFF, 8'h20},
    {8'h80, 8'hFF, 8'h40},
    {8'h30, 8'hEF, 8'h10},
    {8'h00, 8'hFF, 8'h60},
    {8'hF0, 8'h0F, 8'h00},
    {8'h01, 8'hFF, 8'h80},
    {8'h48, 8'hFF, 8'hFE},
    {8'hFF, 8'hAA, 8'h08},
    {8'h00, 8'hFF, 8'hC0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int first_idx(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic serve();
    int k;
    logic [7:0] exp_vec;
    k = first_idx(model & irq_en);
    exp_vec = vec_base + 8'(k);
    chk("R2 int before ack", 32'(cpu_int), 1);
    inta_n = 1'b0; tick();
    chk("R4 int dropped", 32'(cpu_int), 0);
    chk("R4 bus idle in first pulse", 32'(bus_oe), 0);
    chk("R9 in_service", 32'(in_service), 32'(8'(1) << k));
    inta_n = 1'b1; tick();
    chk("R10 no drive between pulses", 32'(bus_oe), 0);
    inta_n = 1'b0; tick();
    chk("R10 drive in second pulse", 32'(bus_oe), 1);
    chk("R5 R6 vector", 32'(bus_data), 32'(exp_vec));
    inta_n = 1'b1; tick();
    model[k] = 1'b0;
    chk("R10 released", 32'(bus_oe), 0);
    chk("R10 data zero", 32'(bus_data), 0);
    chk("R9 in_service clear", 32'(in_service), 0);
    tick();
    chk("R8 int re-assert", 32'(cpu_int), 32'(|(model & irq_en)));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1 int", 32'(cpu_int), 0);
    chk("R1 oe", 32'(bus_oe), 0);
    chk("R1 data", 32'(bus_data), 0);
    chk("R1 in_service", 32'(in_service), 0);
    rst_n = 1'b1; tick();

    // table walk: one-cycle pulses (R3), masking (R2), priority (R6)
    for (int v = 0; v < 9; v++) begin
      irq_en   = VEC[v][15:8];
      vec_base = VEC[v][7:0];
      irq_req  = VEC[v][23:16];
      tick();
      irq_req  = '0;
      model    = model | VEC[v][23:16];
      tick();
      chk("R2 R3 int after pulse", 32'(cpu_int), 32'(|(model & irq_en)));
      while (|(model & irq_en)) serve();
      tick();
      chk("R2 int idle", 32'(cpu_int), 0);
    end

    // R3: held level counts once
    irq_en = '1; vec_base = 8'h30;
    irq_req = 8'h04; tick(); tick();
    model = 8'h04;
    serve();
    tick(); tick(); tick();
    chk("R3 held level no repeat", 32'(cpu_int), 0);
    irq_req = '0; tick();

    // R7: later higher-priority request does not change vector
    vec_base = 8'h50;
    irq_req = 8'h08; tick(); irq_req = '0; tick();
    chk("R7 int up", 32'(cpu_int), 1);
    inta_n = 1'b0; tick();
    inta_n = 1'b1; tick();
    irq_req = 8'h01; tick(); irq_req = '0;
    inta_n = 1'b0; tick();
    chk("R7 frozen vector", 32'(bus_data), 32'h53);
    chk("R7 frozen in_service", 32'(in_service), 32'h08);
    inta_n = 1'b1; tick();
    model = 8'h01;
    tick();
    chk("R8 int for remaining", 32'(cpu_int), 1);
    serve();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule